// File: doc/BRIEF.md
# NAND Page Hamming Code Accumulator

This block sits between a host register bus and a byte-wide NAND flash data path. Every byte the host moves through the flash data window during a data phase is folded into a running Hamming-style code. The code has sixteen line-parity bits, which locate a byte inside a 256-byte chunk, and six column-parity bits, which locate a bit inside a byte. A byte counter supplies the position of each byte within the chunk.

The host clears the accumulators before it transfers a chunk. It then moves the chunk through the data window, in either direction, and reads back the parity bytes and the byte count through fixed register offsets. A packed 24-bit output gives the three code bytes already inverted and ordered for storage in the spare area. Accesses made while the command-latch or address-latch enable is high pass through to the flash but leave the code untouched.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset the line parity, the column parity and the byte counter all read as zero.
- R2: A write to offset 0x14 while latch_cmd and latch_addr are both low folds bus_wdata into the code at the position held by the counter. The counter then increments by one, and the new values can be read in the following cycle.
- R3: A read of offset 0x14 returns flash_din on bus_rdata in the same cycle. When both latch enables are low, that byte is folded into the code in the same way as a write.
- R4: Line parity bit 2k (k = 0..7) accumulates the XOR of the byte parities of all folded bytes whose position bit k is 0. Bit 2k+1 does the same for bytes whose position bit k is 1.
- R5: Column parity bit 2j (j = 0..2) accumulates the XOR of every data bit whose bit index has bit j equal to 0. Bit 2j+1 does the same for data bits whose bit index has bit j equal to 1.
- R6: A data-window access with latch_cmd or latch_addr high still reaches the flash, but it leaves the parity and the counter unchanged.
- R7: Register reads are decoded as follows. Offset 0x00 gives line parity bits 7..0. Offset 0x04 gives line parity bits 15..8. Offset 0x08 gives column parity in bits 5..0, with bits 7..6 reading zero. Offset 0x0C gives the counter.
- R8: Any write to offset 0x10, whatever its data, clears the line parity, the column parity and the counter.
- R9: The counter is 8 bits wide and wraps from 255 to 0. The parity keeps accumulating across the wrap.
- R10: code_o[7:0] is the inverse of line parity bits 15..8. code_o[15:8] is the inverse of line parity bits 7..0. code_o[23:16] is the inverted column parity shifted left by two, with its two low bits forced to 1.
- R11: Writes to offsets 0x00, 0x04, 0x08 and 0x0C have no effect on any stored value.
- R12: A write to offset 0x14 raises flash_we in the same cycle and drives bus_wdata onto flash_dout. A read of offset 0x14 raises flash_re in the same cycle. Neither strobe is raised for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| latch_cmd | input | 1 | Command-latch enable currently presented to the flash |
| latch_addr | input | 1 | Address-latch enable currently presented to the flash |
| flash_din | input | 8 | Byte returned by the flash |
| flash_dout | output | 8 | Byte driven to the flash |
| flash_we | output | 1 | Flash write strobe |
| flash_re | output | 1 | Flash read strobe |
| code_o | output | 24 | Packed three-byte code |

## Verification
Flash strobes, flash_dout and a data-window read of flash_din are combinational. The bench therefore samples them in the same cycle as the access, after the inputs have settled and before the clock edge. Parity, counter and clear updates take effect at the edge that ends the access. A register read, or code_o, in any later cycle must show them, so the bench reads back only in a cycle after that edge. A reference model in the bench folds each byte from the R4 and R5 rules, and the results are compared with it. A hand-worked single-byte case pins the bit positions independently of that model.

// File: rtl/nacc_pkg.sv
package nacc_pkg;
    localparam int BYTE_W     = 8;
    localparam int CHUNK      = 256;
    localparam int CNT_W      = $clog2(CHUNK);
    localparam int LP_W       = 2 * CNT_W;
    localparam int BIDX_W     = $clog2(BYTE_W);
    localparam int CP_W       = 2 * BIDX_W;
    localparam int BUS_AW     = 5;
    localparam int CODE_W     = 3 * BYTE_W;

    localparam logic [BUS_AW-1:0] OFS_LP_LO = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_LP_HI = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_CP    = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_CNT   = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_CLR   = 5'h10;
    localparam logic [BUS_AW-1:0] OFS_DATA  = 5'h14;

    typedef struct packed {
        logic [LP_W-1:0]  lp;
        logic [CP_W-1:0]  cp;
        logic [CNT_W-1:0] cnt;
    } acc_t;
endpackage

// File: rtl/nacc_decode.sv
module nacc_decode
    import nacc_pkg::*;
(
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic              latch_cmd_i,
    input  logic              latch_addr_i,
    output logic              clear_o,
    output logic              fold_o,
    output logic              fwe_o,
    output logic              fre_o
);
    logic win_hit;

    always_comb begin
        win_hit = sel_i && (addr_i == OFS_DATA);
        clear_o = sel_i && wr_i && (addr_i == OFS_CLR);
        fwe_o   = win_hit && wr_i;
        fre_o   = win_hit && !wr_i;
        fold_o  = win_hit && !latch_cmd_i && !latch_addr_i;
    end
endmodule

// File: rtl/nacc_fold.sv
module nacc_fold
    import nacc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CNT_W-1:0]  pos_i,
    output logic [LP_W-1:0]   lp_flip_o,
    output logic [CP_W-1:0]   cp_flip_o
);
    logic bpar;
    assign bpar = ^byte_i;

    for (genvar k = 0; k < CNT_W; k++) begin : g_line
        assign lp_flip_o[2*k]   = bpar & ~pos_i[k];
        assign lp_flip_o[2*k+1] = bpar &  pos_i[k];
    end

    for (genvar j = 0; j < BIDX_W; j++) begin : g_col
        logic ev, od;
        always_comb begin
            ev = 1'b0;
            od = 1'b0;
            for (int i = 0; i < BYTE_W; i++) begin
                if (((i >> j) % 2) == 0) ev = ev ^ byte_i[i];
                else                     od = od ^ byte_i[i];
            end
        end
        assign cp_flip_o[2*j]   = ev;
        assign cp_flip_o[2*j+1] = od;
    end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              latch_cmd,
    input  logic              latch_addr,
    input  logic [BYTE_W-1:0] flash_din,
    output logic [BYTE_W-1:0] flash_dout,
    output logic              flash_we,
    output logic              flash_re,
    output logic [CODE_W-1:0] code_o
);
    acc_t acc_d, acc_q;
    logic clear, fold;
    logic [BYTE_W-1:0] fold_byte;
    logic [LP_W-1:0]   lp_flip, lp_q;
    logic [CP_W-1:0]   cp_flip, cp_q;
    logic [CNT_W-1:0]  cnt_q;

    nacc_decode u_dec (
        .sel_i       (bus_sel),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .latch_cmd_i (latch_cmd),
        .latch_addr_i(latch_addr),
        .clear_o     (clear),
        .fold_o      (fold),
        .fwe_o       (flash_we),
        .fre_o       (flash_re)
    );

    assign fold_byte  = bus_wr ? bus_wdata : flash_din;
    assign flash_dout = bus_wdata;

    nacc_fold u_fold (
        .byte_i   (fold_byte),
        .pos_i    (acc_q.cnt),
        .lp_flip_o(lp_flip),
        .cp_flip_o(cp_flip)
    );

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (fold) begin
            acc_d.lp  = acc_q.lp ^ lp_flip;
            acc_d.cp  = acc_q.cp ^ cp_flip;
            acc_d.cnt = acc_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign lp_q  = acc_q.lp;
    assign cp_q  = acc_q.cp;
    assign cnt_q = acc_q.cnt;

    always_comb begin
        case (bus_addr)
            OFS_LP_LO: bus_rdata = lp_q[BYTE_W-1:0];
            OFS_LP_HI: bus_rdata = lp_q[LP_W-1:BYTE_W];
            OFS_CP:    bus_rdata = {{(BYTE_W-CP_W){1'b0}}, cp_q};
            OFS_CNT:   bus_rdata = cnt_q;
            OFS_DATA:  bus_rdata = flash_din;
            default:   bus_rdata = '0;
        endcase
    end

    assign code_o = {~cp_q, 2'b11, ~lp_q[BYTE_W-1:0], ~lp_q[LP_W-1:BYTE_W]};
endmodule

// File: rtl/nacc_chk.sv
module nacc_chk
    import nacc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              latch_cmd,
    input logic              latch_addr,
    input logic              flash_we,
    input logic              flash_re,
    input logic [LP_W-1:0]   lp,
    input logic [CP_W-1:0]   cp,
    input logic [CNT_W-1:0]  cnt
);
    logic win, quiet;
    assign win   = bus_sel && (bus_addr == OFS_DATA);
    assign quiet = !latch_cmd && !latch_addr;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && bus_wr && quiet) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_CLR) |=> (cnt == '0 && lp == '0 && cp == '0));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !quiet) |=> ($stable(cnt) && $stable(lp) && $stable(cp)));

    // R11
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr < OFS_CLR) |=> ($stable(cnt) && $stable(lp) && $stable(cp)));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && quiet && cnt == '1) |=> (cnt == '0));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_we && flash_re));
endmodule

bind nand_ecc_acc nacc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .latch_cmd (latch_cmd),
    .latch_addr(latch_addr),
    .flash_we  (flash_we),
    .flash_re  (flash_re),
    .lp        (lp_q),
    .cp        (cp_q),
    .cnt       (cnt_q)
);

// File: tb/tb_nand_ecc_acc.sv
module tb_nand_ecc_acc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       latch_cmd = 1'b0, latch_addr = 1'b0;
    logic [7:0] flash_din = '0, flash_dout;
    logic       flash_we, flash_re;
    logic [23:0] code_o;

    int errors = 0, checks = 0;
    logic done = 1'b0;

    logic [15:0] m_lp = '0;
    logic [5:0]  m_cp = '0;
    logic [7:0]  m_cnt = '0;

    always #4 clk = ~clk;

    nand_ecc_acc dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .latch_cmd(latch_cmd), .latch_addr(latch_addr), .flash_din(flash_din),
        .flash_dout(flash_dout), .flash_we(flash_we), .flash_re(flash_re),
        .code_o(code_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic void m_fold(input logic [7:0] b);
        logic p = ^b;
        for (int k = 0; k < 8; k++) begin
            if (m_cnt[k]) m_lp[2*k+1] ^= p;
            else          m_lp[2*k]   ^= p;
        end
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 3; j++) begin
                if (i[j]) m_cp[2*j+1] ^= b[i];
                else      m_cp[2*j]   ^= b[i];
            end
        m_cnt = m_cnt + 8'd1;
    endfunction

    function automatic void m_clear();
        m_lp = '0; m_cp = '0; m_cnt = '0;
    endfunction

    // one bus cycle; samples combinational outputs before the closing edge
    task automatic access(input logic wr, input logic [4:0] a, input logic [7:0] wd,
                          input logic [7:0] fd, output logic [7:0] rd,
                          output logic we, output logic re, output logic [7:0] fdo);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd; flash_din = fd;
        #1;
        rd = bus_rdata; we = flash_we; re = flash_re; fdo = flash_dout;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] rd, fdo; logic we, re;
        access(1'b1, a, d, 8'h00, rd, we, re, fdo);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        logic [7:0] fdo; logic we, re;
        access(1'b0, a, 8'h00, 8'h00, d, we, re, fdo);
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        rd_reg(5'h00, v); chk({req, " lp lo"}, v, m_lp[7:0]);
        rd_reg(5'h04, v); chk({req, " lp hi"}, v, m_lp[15:8]);
        rd_reg(5'h08, v); chk({req, " cp"}, v, {2'b00, m_cp});
        rd_reg(5'h0C, v); chk({req, " cnt"}, v, m_cnt);
        chk({req, " code R10"}, code_o, {~m_cp, 2'b11, ~m_lp[7:0], ~m_lp[15:8]});
    endtask

    task automatic t_reset();
        check_regs("R1 R7");
        chk("R1 R10 code after reset", code_o, 24'hFFFFFF);
    endtask

    task automatic t_single();
        wr_reg(5'h10, 8'h00); m_clear();
        wr_reg(5'h14, 8'h01); m_fold(8'h01);
        chk("R4 single byte lp", m_lp, 16'h5555);
        chk("R5 single byte cp", m_cp, 6'h15);
        check_regs("R2 R4 R5");
        chk("R10 single byte code", code_o, 24'hABAAAA);
    endtask

    task automatic t_read_port();
        logic [7:0] rd, fdo; logic we, re;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = 8'(8'hC3 ^ (i * 29));
            access(1'b0, 5'h14, 8'h00, b, rd, we, re, fdo);
            m_fold(b);
            chk("R3 read port data", rd, b);
            chk("R12 read strobe", {30'd0, re, we}, 32'h2);
        end
        check_regs("R3");
    endtask

    task automatic t_latch();
        logic [7:0] rd, fdo; logic we, re;
        latch_cmd = 1'b1;
        access(1'b1, 5'h14, 8'h90, 8'h00, rd, we, re, fdo);
        chk("R12 write strobe", {30'd0, re, we}, 32'h1);
        chk("R12 flash_dout", fdo, 8'h90);
        latch_cmd = 1'b0; latch_addr = 1'b1;
        access(1'b1, 5'h14, 8'h37, 8'h00, rd, we, re, fdo);
        access(1'b0, 5'h14, 8'h00, 8'h7E, rd, we, re, fdo);
        latch_addr = 1'b0;
        check_regs("R6");
        access(1'b0, 5'h0C, 8'h00, 8'h00, rd, we, re, fdo);
        chk("R12 no strobe elsewhere", {30'd0, re, we}, 32'h0);
    endtask

    task automatic t_ignore();
        wr_reg(5'h00, 8'hFF);
        wr_reg(5'h04, 8'hFF);
        wr_reg(5'h08, 8'hFF);
        wr_reg(5'h0C, 8'hFF);
        check_regs("R11");
    endtask

    task automatic t_clear();
        wr_reg(5'h10, 8'hA5); m_clear();
        check_regs("R8");
        chk("R8 code after clear", code_o, 24'hFFFFFF);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr_reg(5'h10, 8'h00); m_clear();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b = 8'((i * 37 + 5) ^ (i >> 3));
            wr_reg(5'h14, b); m_fold(b);
        end
        rd_reg(5'h0C, v);
        chk("R9 counter wrap", v, 8'h00);
        check_regs("R9 R4 R5");
        wr_reg(5'h14, 8'h6B); m_fold(8'h6B);
        check_regs("R9 after wrap");
    endtask

    task automatic t_mixed();
        logic [7:0] rd, fdo; logic we, re;
        wr_reg(5'h10, 8'h00); m_clear();
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b = 8'(i * 83 + 11);
            if (i % 3 == 0) begin
                access(1'b0, 5'h14, 8'h00, b, rd, we, re, fdo);
                m_fold(b);
            end else begin
                wr_reg(5'h14, b); m_fold(b);
            end
        end
        check_regs("R2 R3 R10 mixed");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_read_port();
        t_latch();
        t_ignore();
        t_clear();
        t_wrap();
        t_mixed();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule